// File: doc/BRIEF.md
# Write-Only Serial Register Target

This block receives register writes over a three-wire serial link (active-low select, serial clock, serial data) and stores them in a small register file inside the system clock domain. All three serial lines are brought into the system clock domain through two-flop synchronisers. Edges of the select and the serial clock are detected there, so the system clock must run at least four times faster than the serial clock.

A frame opens when the select goes low and closes when it returns high. While the select is low, one data bit is taken on each falling edge of the serial clock, most significant bit first. A frame carries 24 bits: an 8-bit register address followed by a 16-bit data word. When the select rises after at least 24 taken bits, the write is committed. The target register updates in the same cycle as a one-cycle write strobe, which carries the address and data. A shorter frame is dropped. Bits after the 24th are ignored.

The register file holds a control word at address 01h, an event word at 02h, a group word at 03h, and eight channel words at 08h through 0Fh. Other addresses are accepted but store nothing.

Top module: `spi_wr_target`

## Requirements
- R1: Out of reset, the control word (address 01h) is 00FFh, the event word (02h), the group word (03h) and all eight channel words are 0000h, and the write strobe is low.
- R2: While sel_n is low, one bit of ser_din is taken on each falling edge of ser_clk, most significant bit first. The first 8 bits form the address (frame bits 23..16) and the last 16 bits form the data (frame bits 15..0).
- R3: A frame with at least 24 taken bits commits on the rise of sel_n. wr_stb is high for exactly one cycle on the 3rd rising clk edge after sel_n rises. wr_addr and wr_data carry the frame, and the addressed register shows the new value in that same cycle.
- R4: A frame with fewer than 24 taken bits changes no register and raises no strobe.
- R5: A frame with more than 24 falling edges commits only its first 24 bits, and the bit counter never exceeds 24.
- R6: A committed write to an address outside 01h, 02h, 03h and 08h..0Fh still strobes, but no register changes.
- R7: Address 01h writes the control word, 02h the event word, 03h the group word, and 08h+i writes channel word i, which occupies ch_word bits [16*i+15:16*i].
- R8: ser_clk edges while sel_n is high take no bits and change nothing.
- R9: A register output changes only in a cycle where wr_stb is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock; may be gated or free-running |
| ser_din | input | 1 | Serial data, MSB first |
| ctl_word | output | 16 | Register 01h |
| evt_word | output | 16 | Register 02h |
| grp_word | output | 16 | Register 03h |
| ch_word | output | 128 | Channel words 08h..0Fh; channel i in bits [16*i+15:16*i] |
| wr_stb | output | 1 | One-cycle commit strobe |
| wr_addr | output | 8 | Address of the last committed frame |
| wr_data | output | 16 | Data of the last committed frame |

## Verification
A wrong bit count or shift contents shows at the ports within three clock cycles of the select rising. The failure is a missing or extra strobe, a strobe at the wrong cycle, or a wrong wr_addr/wr_data. A decode fault shows as the wrong register word differing from the bench's model at that same sample. After every frame, the bench compares the whole register file with an arithmetic model. It sweeps every one of the 256 addresses and every frame length from 0 to 40 edges, so a fault that corrupts a neighbouring register or wraps the counter is seen on the first frame that triggers it.

// File: rtl/spi_wr_target.sv
module spi_wr_target #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int NCH = 8,
  parameter logic [AW-1:0] ADDR_CTL = 'h01,
  parameter logic [AW-1:0] ADDR_EVT = 'h02,
  parameter logic [AW-1:0] ADDR_GRP = 'h03,
  parameter logic [AW-1:0] CH_BASE = 'h08,
  parameter logic [DW-1:0] CTL_RST = 'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic [DW-1:0]     ctl_word,
  output logic [DW-1:0]     evt_word,
  output logic [DW-1:0]     grp_word,
  output logic [NCH*DW-1:0] ch_word,
  output logic              wr_stb,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data
);
  localparam int FB = AW + DW;
  localparam int CW = $clog2(FB + 1);

  logic [1:0] sel_s, ck_s, di_s;
  logic sel_d, ck_d;
  logic [FB-1:0] sh;
  logic [CW-1:0] cnt;

  wire active  = ~sel_s[1];
  wire ck_fall = ck_d & ~ck_s[1];
  wire sel_ris = ~sel_d & sel_s[1];
  wire commit  = sel_ris && (cnt == CW'(FB));
  wire [AW-1:0] f_addr = sh[FB-1:DW];
  wire [DW-1:0] f_data = sh[DW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_s <= 2'b11;
      ck_s  <= 2'b11;
      di_s  <= 2'b00;
      sel_d <= 1'b1;
      ck_d  <= 1'b1;
    end else begin
      sel_s <= {sel_s[0], sel_n};
      ck_s  <= {ck_s[0], ser_clk};
      di_s  <= {di_s[0], ser_din};
      sel_d <= sel_s[1];
      ck_d  <= ck_s[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else if (ck_fall && cnt < CW'(FB)) begin
      sh  <= {sh[FB-2:0], di_s[1]};
      cnt <= cnt + CW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= commit;
      if (commit) begin
        wr_addr <= f_addr;
        wr_data <= f_data;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_word <= CTL_RST;
      evt_word <= '0;
      grp_word <= '0;
    end else if (commit) begin
      if (f_addr == ADDR_CTL) ctl_word <= f_data;
      if (f_addr == ADDR_EVT) evt_word <= f_data;
      if (f_addr == ADDR_GRP) grp_word <= f_data;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] MYADDR = AW'(int'(CH_BASE) + i);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ch_word[i*DW +: DW] <= '0;
      else if (commit && f_addr == MYADDR) ch_word[i*DW +: DW] <= f_data;

    a_r7_ch_written: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == MYADDR) |-> ch_word[i*DW +: DW] == wr_data);
  end

  a_r5_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FB));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r7_ctl_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == ADDR_CTL) |-> ctl_word == wr_data);
  a_r9_ctl_only_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word != $past(ctl_word)) |-> wr_stb);
  a_r9_regs_only_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_word != $past(evt_word) || grp_word != $past(grp_word)
     || ch_word != $past(ch_word)) |-> wr_stb);
  a_r6_unmapped_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr != ADDR_CTL && wr_addr != ADDR_EVT && wr_addr != ADDR_GRP
     && (int'(wr_addr) < int'(CH_BASE) || int'(wr_addr) >= int'(CH_BASE) + NCH))
    |-> ($stable(ctl_word) && $stable(evt_word) && $stable(grp_word) && $stable(ch_word)));
endmodule

// File: tb/tb_spi_wr_target.sv
module tb_spi_wr_target;
  logic clk = 0, rst_n = 0, sel_n = 1, ser_clk = 1, ser_din = 0;
  logic [15:0] ctl_word, evt_word, grp_word, wr_data;
  logic [127:0] ch_word;
  logic wr_stb;
  logic [7:0] wr_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_ctl, m_evt, m_grp;
  logic [15:0] m_ch [8];

  spi_wr_target dut (.clk, .rst_n, .sel_n, .ser_clk, .ser_din, .ctl_word, .evt_word,
                     .grp_word, .ch_word, .wr_stb, .wr_addr, .wr_data);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_regs(string tag);
    logic [127:0] e;
    for (int i = 0; i < 8; i++) e[i*16 +: 16] = m_ch[i];
    chk({tag, " ctl"}, ctl_word, m_ctl);
    chk({tag, " evt"}, evt_word, m_evt);
    chk({tag, " grp"}, grp_word, m_grp);
    chk({tag, " ch"}, ch_word, e);
  endtask

  task automatic model(logic [7:0] a, logic [15:0] d);
    if (a == 8'h01) m_ctl = d;
    else if (a == 8'h02) m_evt = d;
    else if (a == 8'h03) m_grp = d;
    else if (a >= 8'h08 && a <= 8'h0F) m_ch[a - 8'h08] = d;
  endtask

  // n falling edges with sel_n low; bits past 24 come from 'tail'
  task automatic frame(logic [7:0] a, logic [15:0] d, int n, logic [15:0] tail, string tag);
    logic [23:0] w = {a, d};
    bit good = (n >= 24);
    sel_n = 0;
    cyc(4);
    for (int i = 0; i < n; i++) begin
      ser_din = (i < 24) ? w[23 - i] : tail[i % 16];
      cyc(2);
      ser_clk = 0;
      cyc(4);
      ser_clk = 1;
      cyc(2);
    end
    cyc(4);
    sel_n = 1;
    cyc(2);
    chk({tag, " R3 no early stb"}, wr_stb, 0);
    if (good) model(a, d);
    cyc(1);
    chk({tag, good ? " R3 stb" : " R4 no stb"}, wr_stb, good);
    if (good) begin
      chk({tag, " R2 addr"}, wr_addr, a);
      chk({tag, " R2 data"}, wr_data, d);
    end
    chk_regs({tag, good ? " R7 regs" : " R4 regs"});
    cyc(1);
    chk({tag, " R3 one cycle"}, wr_stb, 0);
    cyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_ctl = 16'h00FF; m_evt = 0; m_grp = 0;
    for (int i = 0; i < 8; i++) m_ch[i] = 0;
    cyc(3);
    chk_regs("R1 reset");
    chk("R1 stb", wr_stb, 0);
    rst_n = 1;
    cyc(3);
    // R6/R7: every address once
    for (int a = 0; a < 256; a++)
      frame(8'(a), 16'(a * 16'h0101) ^ 16'h5A3C, 24, 16'h0, "sweep");
    // R4: every short length, target a mapped register
    for (int n = 0; n < 24; n++)
      frame(8'h08 + 8'(n % 8), 16'hFFFF ^ 16'(n), n, 16'h0, "short");
    // R5: overlong frames with all-ones/all-zeros tails
    for (int n = 25; n <= 40; n++)
      frame(8'h01 + 8'(n % 3), 16'(n * 777), n, (n % 2) ? 16'hFFFF : 16'h0000, "R5 long");
    // R8: clock activity with select high takes no bits
    for (int i = 0; i < 30; i++) begin
      ser_din = 1;
      ser_clk = 0; cyc(4);
      ser_clk = 1; cyc(4);
      chk("R8 idle stb", wr_stb, 0);
    end
    chk_regs("R8 idle regs");
    frame(8'h0F, 16'hBEEF, 23, 16'h0, "R8 short after idle edges");
    frame(8'h0F, 16'hBEEF, 24, 16'h0, "R8 full after idle edges");
    frame(8'h40, 16'h1234, 24, 16'h0, "R6 unmapped");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule